// File: doc/BRIEF.md
# Raster Scan Timing and Framebuffer Address Generator

This block drives the control side of a parallel RGB display panel. Counters clocked by the system clock produce a divided pixel clock. They then split each line into a sync pulse, a back porch, a visible run and a front porch, and split each frame into lines the same way. From this position the block drives five panel strobes: panel select, pixel clock, data enable, line sync and frame sync. Each strobe has its own active level. A sixth signal marks the system-clock cycles in which RGB data should be on the pins, placed around the active pixel-clock edge.

Alongside the timing, the block keeps a line pointer into a framebuffer. For each visible pixel it presents the byte address to fetch. It also reports how far the scan has moved through the visible columns and rows. The pointer is reloaded from a base offset either once per frame or once per line, and grows by a per-line byte stride. Fetching the pixel data is left to a separate memory reader. All timing inputs are expected to stay unchanged while out of reset. A common panel setting is 320 visible columns with a 2-pixel sync, a back porch of 29 and a front porch of 1. The matching frame is 240 visible rows with a 2-line sync, a back porch of 4 and a front porch of 1, a 5-cycle pixel period, and both data setup and data hold of 1.

Top module: `lcd_scan_timer`

## Requirements
- R1: While rstN is low, hCount, vCount and fbAddr are 0 and the panel-select and data-enable pins are at their inactive level. Panel select becomes active from the first rising clock edge after reset is released and stays active.
- R2: The pixel period is pixPeriod system cycles, with 0 treated as 1. Within each period, the phase runs from 0 to period-1. The pixel clock is inactive for phases below startPos and active from phase startPos to the end of the period.
- R3: A line is hPulseSize+hBackSize+hVisSize+hFrontSize pixel periods long. The line-sync pin is active during the first hPulseSize pixels of every line.
- R4: A frame is vPulseSize+vBackSize+vVisSize+vFrontSize lines long. The frame-sync pin is active during the first vPulseSize lines, and it changes only at line boundaries.
- R5: Data enable is active exactly when the column lies in [hPulseSize+hBackSize, +hVisSize) and the row lies in [vPulseSize+vBackSize, +vVisSize).
- R6: hCount is 0 before the visible columns of a line, equals the index of the current visible column inside them, and holds hVisSize after them. vCount behaves the same way for rows over a frame. hCount changes only after a pixel-period end, and vCount changes only after a line end.
- R7: During data enable, fbAddr equals the line pointer plus hCount shifted left by pixelWide. pixelWide 0 gives a 1-byte step and pixelWide 1 gives a 2-byte step. The sum wraps modulo 2^ADDR_W.
- R8: With reloadOnHsync = 0, the line pointer takes frameBase at the end of the last frame-sync line and grows by lineStride at the end of every visible line. Visible row i therefore starts at frameBase + i*lineStride.
- R9: With reloadOnHsync = 1, the line pointer takes frameBase at the end of the last line-sync pixel of every line. Every visible row therefore starts at frameBase.
- R10: rgbDrive is high exactly when data enable is active and the phase p satisfies startPos-setupCyc <= p < startPos+holdCyc.
- R11: Bit positions in polHigh are 0 panel select, 1 pixel clock, 2 data enable, 3 line sync and 4 frame sync. A bit value of 1 makes its pin active high, and a value of 0 makes it active low.
- R12: With dclkOnFall = 1, the pixel-clock pin takes its new level at the falling clock edge after the rising edge that changes the phase, a half cycle later than with dclkOnFall = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hVisSize | input | POS_W | Visible columns per line |
| hFrontSize | input | POS_W | Pixels after the visible run |
| hBackSize | input | POS_W | Pixels between line sync and visible run |
| hPulseSize | input | POS_W | Line-sync width in pixels |
| vVisSize | input | POS_W | Visible rows per frame |
| vFrontSize | input | POS_W | Lines after the visible rows |
| vBackSize | input | POS_W | Lines between frame sync and visible rows |
| vPulseSize | input | POS_W | Frame-sync width in lines |
| pixPeriod | input | DIV_W | Pixel period in system cycles |
| startPos | input | DIV_W | Phase of the active pixel-clock edge |
| setupCyc | input | DIV_W | Data cycles before the active edge |
| holdCyc | input | DIV_W | Data cycles from the active edge on |
| polHigh | input | 5 | Per-pin active-high selects |
| dclkOnFall | input | 1 | Launch pixel clock on the falling edge |
| reloadOnHsync | input | 1 | 1: reload pointer every line, 0: every frame |
| pixelWide | input | 1 | Address step, 0: 1 byte, 1: 2 bytes |
| frameBase | input | ADDR_W | Pointer reload value |
| lineStride | input | STRIDE_W | Bytes added after each visible line |
| csOut | output | 1 | Panel select pin |
| dclkOut | output | 1 | Pixel clock pin |
| deOut | output | 1 | Data enable pin |
| hsyncOut | output | 1 | Line sync pin |
| vsyncOut | output | 1 | Frame sync pin |
| rgbDrive | output | 1 | RGB data drive window, active high |
| hCount | output | POS_W | Visible column position |
| vCount | output | POS_W | Visible row position |
| fbAddr | output | ADDR_W | Framebuffer byte address of current pixel |

## Verification
The hardest cases to reach are the ones where several boundaries fall on the same clock edge. Examples are a zero front porch, where the last visible pixel ends the line, or the last visible row, which ends the frame. A zero back porch makes the pointer reload land right before the first visible pixel. A one-cycle pixel period makes every cycle a pixel boundary. The stimulus table holds a handful of small timing sets chosen so that each of these coincidences occurs within a few frames. A base near the top of the address space also forces wrap-around. Every cycle of several complete frames is then compared against position-derived expectations.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int PIN_CS    = 0;
  localparam int PIN_DCLK  = 1;
  localparam int PIN_DE    = 2;
  localparam int PIN_HSYNC = 3;
  localparam int PIN_VSYNC = 4;
  localparam int PIN_COUNT = 5;

  // Strobes from the scan control to the address datapath and pin stage
  typedef struct packed {
    logic pixTick;    // last phase of a pixel period
    logic lineEnd;    // last phase of the last pixel of a line
    logic frameEnd;   // lineEnd on the last line of a frame
    logic hVis;       // column inside visible run
    logic vVis;       // row inside visible run
    logic deAct;      // both visible
    logic hSyncAct;
    logic vSyncAct;
    logic hPulseEnd;  // end of last line-sync pixel
    logic vPulseEnd;  // end of last frame-sync line
    logic dclkAct;
    logic driveWin;
    logic panelOn;
  } scan_strobe_t;

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int POS_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] hVisSize,
  input  logic [POS_W-1:0] hFrontSize,
  input  logic [POS_W-1:0] hBackSize,
  input  logic [POS_W-1:0] hPulseSize,
  input  logic [POS_W-1:0] vVisSize,
  input  logic [POS_W-1:0] vFrontSize,
  input  logic [POS_W-1:0] vBackSize,
  input  logic [POS_W-1:0] vPulseSize,
  input  logic [DIV_W-1:0] pixPeriod,
  input  logic [DIV_W-1:0] startPos,
  input  logic [DIV_W-1:0] setupCyc,
  input  logic [DIV_W-1:0] holdCyc,
  output scan_strobe_t     strobes
);

  localparam int SUM_W = POS_W + 2;
  localparam int PH_W  = DIV_W + 1;

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] hPos;
  logic [POS_W-1:0] vPos;
  logic             panelOn;

  logic [DIV_W-1:0] periodLast;
  logic [SUM_W-1:0] hStart, hEnd, hTot, hLast;
  logic [SUM_W-1:0] vStart, vEnd, vTot, vLast;
  logic [SUM_W-1:0] hPosX, vPosX;
  logic [PH_W-1:0]  phaseX, earlyX, lateX;
  logic             pixTick, lineEnd, frameEnd, hVis, vVis;

  always_comb begin
    periodLast = (pixPeriod == '0) ? '0 : pixPeriod - 1'b1;
    hPosX  = SUM_W'(hPos);
    vPosX  = SUM_W'(vPos);
    hStart = SUM_W'(hPulseSize) + SUM_W'(hBackSize);
    hEnd   = hStart + SUM_W'(hVisSize);
    hTot   = hEnd + SUM_W'(hFrontSize);
    hLast  = (hTot == '0) ? '0 : hTot - 1'b1;
    vStart = SUM_W'(vPulseSize) + SUM_W'(vBackSize);
    vEnd   = vStart + SUM_W'(vVisSize);
    vTot   = vEnd + SUM_W'(vFrontSize);
    vLast  = (vTot == '0) ? '0 : vTot - 1'b1;

    pixTick  = (divCnt >= periodLast);
    lineEnd  = pixTick && (hPosX >= hLast);
    frameEnd = lineEnd && (vPosX >= vLast);
    hVis     = (hPosX >= hStart) && (hPosX < hEnd);
    vVis     = (vPosX >= vStart) && (vPosX < vEnd);

    phaseX = PH_W'(divCnt);
    earlyX = phaseX + PH_W'(setupCyc);
    lateX  = PH_W'(startPos) + PH_W'(holdCyc);
  end

  always_comb begin
    strobes.pixTick   = pixTick;
    strobes.lineEnd   = lineEnd;
    strobes.frameEnd  = frameEnd;
    strobes.hVis      = hVis;
    strobes.vVis      = vVis;
    strobes.deAct     = hVis && vVis;
    strobes.hSyncAct  = (hPos < hPulseSize);
    strobes.vSyncAct  = (vPos < vPulseSize);
    strobes.hPulseEnd = pixTick && (hPulseSize != '0) && (hPos == hPulseSize - 1'b1);
    strobes.vPulseEnd = lineEnd && (vPulseSize != '0) && (vPos == vPulseSize - 1'b1);
    strobes.dclkAct   = (divCnt >= startPos);
    strobes.driveWin  = hVis && vVis && (earlyX >= PH_W'(startPos)) && (phaseX < lateX);
    strobes.panelOn   = panelOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      hPos    <= '0;
      vPos    <= '0;
      panelOn <= 1'b0;
    end else begin
      panelOn <= 1'b1;
      if (pixTick) divCnt <= '0;
      else         divCnt <= divCnt + 1'b1;
      if (lineEnd)      hPos <= '0;
      else if (pixTick) hPos <= hPos + 1'b1;
      if (frameEnd)     vPos <= '0;
      else if (lineEnd) vPos <= vPos + 1'b1;
    end
  end

endmodule

// File: rtl/lcd_scan_dpath.sv
module lcd_scan_dpath
  import lcd_scan_pkg::*;
#(
  parameter int POS_W    = 12,
  parameter int ADDR_W   = 24,
  parameter int STRIDE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  scan_strobe_t        st,
  input  logic [ADDR_W-1:0]   frameBase,
  input  logic [STRIDE_W-1:0] lineStride,
  input  logic                pixelWide,
  input  logic                reloadOnHsync,
  output logic [POS_W-1:0]    hCount,
  output logic [POS_W-1:0]    vCount,
  output logic [ADDR_W-1:0]   fbAddr
);

  logic [POS_W-1:0]  hCnt, vCnt;
  logic [ADDR_W-1:0] linePtr;
  logic [ADDR_W-1:0] pixOff;
  logic              reloadNow;
  logic              unusedStrobes;

  assign unusedStrobes = ^{st.deAct, st.hSyncAct, st.vSyncAct, st.dclkAct,
                           st.driveWin, st.panelOn};

  always_comb begin
    reloadNow = reloadOnHsync ? st.hPulseEnd : st.vPulseEnd;
    pixOff    = ADDR_W'(hCnt) << pixelWide;
    fbAddr    = linePtr + pixOff;
    hCount    = hCnt;
    vCount    = vCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      linePtr <= '0;
    end else begin
      if (st.lineEnd)                hCnt <= '0;
      else if (st.pixTick && st.hVis) hCnt <= hCnt + 1'b1;

      if (st.frameEnd)               vCnt <= '0;
      else if (st.lineEnd && st.vVis) vCnt <= vCnt + 1'b1;

      if (reloadNow)                 linePtr <= frameBase;
      else if (st.lineEnd && st.vVis) linePtr <= linePtr + ADDR_W'(lineStride);
    end
  end

endmodule

// File: rtl/lcd_scan_pins.sv
module lcd_scan_pins
  import lcd_scan_pkg::*;
#(
  parameter int NPIN     = PIN_COUNT,
  parameter int DCLK_IDX = PIN_DCLK
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NPIN-1:0] actVec,
  input  logic [NPIN-1:0] polHigh,
  input  logic            dclkOnFall,
  output logic [NPIN-1:0] pinVec
);

  logic            dclkFall;
  logic [NPIN-1:0] srcVec;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) dclkFall <= 1'b0;
    else       dclkFall <= actVec[DCLK_IDX];
  end

  always_comb begin
    srcVec = actVec;
    if (dclkOnFall) srcVec[DCLK_IDX] = dclkFall;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pinVec[i] = polHigh[i] ? srcVec[i] : ~srcVec[i];
  end

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int POS_W    = 12,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 24,
  parameter int STRIDE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [POS_W-1:0]    hVisSize,
  input  logic [POS_W-1:0]    hFrontSize,
  input  logic [POS_W-1:0]    hBackSize,
  input  logic [POS_W-1:0]    hPulseSize,
  input  logic [POS_W-1:0]    vVisSize,
  input  logic [POS_W-1:0]    vFrontSize,
  input  logic [POS_W-1:0]    vBackSize,
  input  logic [POS_W-1:0]    vPulseSize,
  input  logic [DIV_W-1:0]    pixPeriod,
  input  logic [DIV_W-1:0]    startPos,
  input  logic [DIV_W-1:0]    setupCyc,
  input  logic [DIV_W-1:0]    holdCyc,
  input  logic [4:0]          polHigh,
  input  logic                dclkOnFall,
  input  logic                reloadOnHsync,
  input  logic                pixelWide,
  input  logic [ADDR_W-1:0]   frameBase,
  input  logic [STRIDE_W-1:0] lineStride,
  output logic                csOut,
  output logic                dclkOut,
  output logic                deOut,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                rgbDrive,
  output logic [POS_W-1:0]    hCount,
  output logic [POS_W-1:0]    vCount,
  output logic [ADDR_W-1:0]   fbAddr
);

  scan_strobe_t           strobes;
  logic [PIN_COUNT-1:0]   actVec;
  logic [PIN_COUNT-1:0]   pinVec;

  lcd_scan_ctrl #(.POS_W(POS_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hVisSize(hVisSize), .hFrontSize(hFrontSize), .hBackSize(hBackSize), .hPulseSize(hPulseSize),
    .vVisSize(vVisSize), .vFrontSize(vFrontSize), .vBackSize(vBackSize), .vPulseSize(vPulseSize),
    .pixPeriod(pixPeriod), .startPos(startPos), .setupCyc(setupCyc), .holdCyc(holdCyc),
    .strobes(strobes)
  );

  lcd_scan_dpath #(.POS_W(POS_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .st(strobes),
    .frameBase(frameBase), .lineStride(lineStride),
    .pixelWide(pixelWide), .reloadOnHsync(reloadOnHsync),
    .hCount(hCount), .vCount(vCount), .fbAddr(fbAddr)
  );

  always_comb begin
    actVec            = '0;
    actVec[PIN_CS]    = strobes.panelOn;
    actVec[PIN_DCLK]  = strobes.dclkAct;
    actVec[PIN_DE]    = strobes.deAct;
    actVec[PIN_HSYNC] = strobes.hSyncAct;
    actVec[PIN_VSYNC] = strobes.vSyncAct;
  end

  lcd_scan_pins #(.NPIN(PIN_COUNT), .DCLK_IDX(PIN_DCLK)) pins_i (
    .clk(clk), .rstN(rstN), .actVec(actVec), .polHigh(polHigh),
    .dclkOnFall(dclkOnFall), .pinVec(pinVec)
  );

  assign csOut    = pinVec[PIN_CS];
  assign dclkOut  = pinVec[PIN_DCLK];
  assign deOut    = pinVec[PIN_DE];
  assign hsyncOut = pinVec[PIN_HSYNC];
  assign vsyncOut = pinVec[PIN_VSYNC];
  assign rgbDrive = strobes.driveWin;

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk
  import lcd_scan_pkg::*;
#(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input scan_strobe_t     st,
  input logic [POS_W-1:0] hCount,
  input logic [POS_W-1:0] vCount,
  input logic [POS_W-1:0] hVisSize,
  input logic [POS_W-1:0] vVisSize
);

  logic unusedStrobes;
  assign unusedStrobes = ^{st.frameEnd, st.hVis, st.vVis, st.hPulseEnd, st.vPulseEnd,
                           st.dclkAct, st.driveWin, st.panelOn};

  AST_DE_OUTSIDE_HSYNC: assert property (@(posedge clk) disable iff (!rstN)
    st.deAct |-> !st.hSyncAct);  // R5

  AST_HCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    hCount <= hVisSize);  // R6

  AST_VCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    vCount <= vVisSize);  // R6

  AST_HCOUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.pixTick) |-> $stable(hCount));  // R6

  AST_VCOUNT_ON_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.lineEnd) |-> $stable(vCount));  // R6

  AST_VSYNC_ON_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.lineEnd) |-> $stable(st.vSyncAct));  // R4

endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rstN(rstN), .st(strobes),
  .hCount(hCount), .vCount(vCount),
  .hVisSize(hVisSize), .vVisSize(vVisSize)
);

// File: tb/lcd_scan_timer_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_timer_tb_top;

  typedef struct packed {
    logic [11:0] hV, hF, hB, hP;
    logic [11:0] vV, vF, vB, vP;
    logic [7:0]  per, st, su, ho;
    logic [4:0]  pol;
    logic        wide, hsMode;
    logic [23:0] base;
    logic [11:0] stride;
  } cfg_t;

  // visible/front/back/pulse (h then v), period, start, setup, hold, pol, wide, mode, base, stride
  localparam cfg_t CFGS [4] = '{
    '{12'd4, 12'd1, 12'd2, 12'd1, 12'd3, 12'd1, 12'd1, 12'd1, 8'd3, 8'd1, 8'd1, 8'd1,
      5'b00000, 1'b0, 1'b0, 24'h000100, 12'h020},
    '{12'd5, 12'd0, 12'd1, 12'd2, 12'd2, 12'd0, 12'd2, 12'd2, 8'd4, 8'd2, 8'd2, 8'd2,
      5'b11111, 1'b1, 1'b1, 24'h000040, 12'h010},
    '{12'd3, 12'd2, 12'd0, 12'd1, 12'd4, 12'd2, 12'd0, 12'd1, 8'd1, 8'd0, 8'd0, 8'd1,
      5'b10101, 1'b1, 1'b0, 24'hFFFFF0, 12'hFFF},
    '{12'd6, 12'd1, 12'd1, 12'd3, 12'd2, 12'd1, 12'd1, 12'd1, 8'd2, 8'd1, 8'd1, 8'd1,
      5'b01010, 1'b0, 1'b0, 24'h000010, 12'h008}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] hVisSize, hFrontSize, hBackSize, hPulseSize;
  logic [11:0] vVisSize, vFrontSize, vBackSize, vPulseSize;
  logic [7:0]  pixPeriod, startPos, setupCyc, holdCyc;
  logic [4:0]  polHigh;
  logic        dclkOnFall, reloadOnHsync, pixelWide;
  logic [23:0] frameBase;
  logic [11:0] lineStride;
  logic        csOut, dclkOut, deOut, hsyncOut, vsyncOut, rgbDrive;
  logic [11:0] hCount, vCount;
  logic [23:0] fbAddr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lcd_scan_timer dut_i (
    .clk(clk), .rstN(rstN),
    .hVisSize(hVisSize), .hFrontSize(hFrontSize), .hBackSize(hBackSize), .hPulseSize(hPulseSize),
    .vVisSize(vVisSize), .vFrontSize(vFrontSize), .vBackSize(vBackSize), .vPulseSize(vPulseSize),
    .pixPeriod(pixPeriod), .startPos(startPos), .setupCyc(setupCyc), .holdCyc(holdCyc),
    .polHigh(polHigh), .dclkOnFall(dclkOnFall), .reloadOnHsync(reloadOnHsync),
    .pixelWide(pixelWide), .frameBase(frameBase), .lineStride(lineStride),
    .csOut(csOut), .dclkOut(dclkOut), .deOut(deOut), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .rgbDrive(rgbDrive),
    .hCount(hCount), .vCount(vCount), .fbAddr(fbAddr)
  );

  task automatic chk(input string req, input string what, input longint actV, input longint expV);
    total++;
    if (actV != expV) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, actV, expV, $time);
    end
  endtask

  function automatic logic pinLvl(input bit act, input logic pol);
    return pol ? logic'(act) : logic'(!act);
  endfunction

  function automatic int perOf(input cfg_t c);
    return (c.per == 0) ? 1 : int'(c.per);
  endfunction

  task automatic loadCfg(input cfg_t c, input logic fallMode);
    hVisSize = c.hV; hFrontSize = c.hF; hBackSize = c.hB; hPulseSize = c.hP;
    vVisSize = c.vV; vFrontSize = c.vF; vBackSize = c.vB; vPulseSize = c.vP;
    pixPeriod = c.per; startPos = c.st; setupCyc = c.su; holdCyc = c.ho;
    polHigh = c.pol; pixelWide = c.wide; reloadOnHsync = c.hsMode;
    frameBase = c.base; lineStride = c.stride; dclkOnFall = fallMode;
  endtask

  // Expected outputs n rising edges after reset release
  task automatic checkAt(input cfg_t c, input logic fallMode, input int n);
    int P      = perOf(c);
    int hTot   = int'(c.hP) + int'(c.hB) + int'(c.hV) + int'(c.hF);
    int vTot   = int'(c.vP) + int'(c.vB) + int'(c.vV) + int'(c.vF);
    int ph     = n % P;
    int pix    = n / P;
    int hPos   = pix % hTot;
    int vPos   = (pix / hTot) % vTot;
    int hStart = int'(c.hP) + int'(c.hB);
    int vStart = int'(c.vP) + int'(c.vB);
    bit hv     = (hPos >= hStart) && (hPos < hStart + int'(c.hV));
    bit vv     = (vPos >= vStart) && (vPos < vStart + int'(c.vV));
    bit de     = hv && vv;
    int hc     = (hPos < hStart) ? 0 : ((hPos - hStart > int'(c.hV)) ? int'(c.hV) : hPos - hStart);
    int vc     = (vPos < vStart) ? 0 : ((vPos - vStart > int'(c.vV)) ? int'(c.vV) : vPos - vStart);
    bit drv    = de && (ph + int'(c.su) >= int'(c.st)) && (ph < int'(c.st) + int'(c.ho));
    longint ptr;
    longint expAddr;
    chk("R3", "hsync", hsyncOut, pinLvl(hPos < int'(c.hP), c.pol[3]));
    chk("R4", "vsync", vsyncOut, pinLvl(vPos < int'(c.vP), c.pol[4]));
    chk("R5", "de", deOut, pinLvl(de, c.pol[2]));
    chk("R1", "cs", csOut, pinLvl(n >= 1, c.pol[0]));
    if (!fallMode)
      chk("R2", "dclk", dclkOut, pinLvl(ph >= int'(c.st), c.pol[1]));
    else if (n > 0)
      chk("R12", "dclk before fall edge", dclkOut, pinLvl(((n - 1) % P) >= int'(c.st), c.pol[1]));
    chk("R6", "hCount", hCount, hc);
    chk("R6", "vCount", vCount, vc);
    chk("R10", "rgbDrive", rgbDrive, drv);
    if (de) begin
      ptr = c.hsMode ? longint'(c.base) : longint'(c.base) + longint'(vc) * longint'(c.stride);
      expAddr = (ptr + (longint'(hc) << c.wide)) & 64'hFFFFFF;
      chk(c.hsMode ? "R7 R9" : "R7 R8", "fbAddr", fbAddr, expAddr);
    end
  endtask

  task automatic runCfg(input cfg_t c, input logic fallMode, input int cycles);
    loadCfg(c, fallMode);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int n = 0; n <= cycles; n++) begin
      if (n > 0) begin
        @(posedge clk);
        #1;
      end
      checkAt(c, fallMode, n);
      if (fallMode && n > 0) begin
        #2;
        chk("R12", "dclk after fall edge", dclkOut, pinLvl((n % perOf(c)) >= int'(c.st), c.pol[1]));
      end
    end
  endtask

  initial begin
    loadCfg(CFGS[0], 1'b0);

    // Table walk: several whole frames per timing set
    for (int k = 0; k < 4; k++) begin
      int frameCyc = perOf(CFGS[k]) *
        (int'(CFGS[k].hP) + int'(CFGS[k].hB) + int'(CFGS[k].hV) + int'(CFGS[k].hF)) *
        (int'(CFGS[k].vP) + int'(CFGS[k].vB) + int'(CFGS[k].vV) + int'(CFGS[k].vF));
      runCfg(CFGS[k], 1'b0, 3 * frameCyc + 4);
    end

    // R1: state held in reset
    loadCfg(CFGS[0], 1'b0);
    polHigh = 5'b11111;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "hCount in reset", hCount, 0);
    chk("R1", "vCount in reset", vCount, 0);
    chk("R1", "fbAddr in reset", fbAddr, 0);
    chk("R1", "de in reset", deOut, 0);
    chk("R1", "cs in reset", csOut, 0);
    // R11: per-pin polarity, order {vsync,hsync,de,dclk,cs}
    chk("R11", "pins active high", {vsyncOut, hsyncOut, deOut, dclkOut, csOut}, 5'b11000);
    polHigh = 5'b00000;
    #1;
    chk("R11", "pins active low", {vsyncOut, hsyncOut, deOut, dclkOut, csOut}, 5'b00111);
    polHigh = 5'b01001;
    #1;
    chk("R11", "pins mixed", {vsyncOut, hsyncOut, deOut, dclkOut, csOut}, 5'b01110);

    // R12: pixel clock launched from the falling edge
    runCfg(CFGS[0], 1'b1, 60);
    runCfg(CFGS[3], 1'b1, 40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule